// File: doc/BRIEF.md
# Ripple-Carry Bit-Sliced ALU

This block is a purely combinational integer ALU. It is built from a row of identical one-bit slices, and each slice carries a carry into the next. Every slice holds an AND gate, an OR gate, a full adder and a four-way output selector. Every slice also has an inverter on the second operand, and one shared control line drives it. That same line is the carry into the lowest slice, so asserting it together with the add selection gives a two's-complement subtraction.

The top slice also derives the signed-overflow flag and a corrected sign of the adder output. That corrected sign is fed back into the "less" input of the lowest slice, and the less inputs of all other slices are tied low. The fourth selector code turns this into a set-on-signed-less-than result.

A zero flag reports an all-zero result, so an equality compare is a subtraction followed by a look at that flag. The carry and overflow outputs always reflect the adder, whichever operation is selected.

Top module: `alu_ripple`

## Requirements
- R1: With op_i = 0 the result is the bitwise AND of a_i and the effective second operand (b_i, or ~b_i when b_invert_i = 1).
- R2: With op_i = 1 the result is the bitwise OR of a_i and the effective second operand.
- R3: With op_i = 2 and b_invert_i = 0 the result is the low WIDTH bits of a_i + b_i, and carry_o is the carry out of the top bit.
- R4: With op_i = 2 and b_invert_i = 1 the result is a_i - b_i modulo 2^WIDTH. carry_o is 1 exactly when a_i >= b_i as unsigned values.
- R5: overflow_o is 1 exactly when the adder's signed result overflows, meaning the carry into the top bit differs from the carry out of it. This holds for any op_i.
- R6: With op_i = 3 and b_invert_i = 1, result bit 0 is 1 exactly when a_i < b_i as signed values, and this includes cases where a_i - b_i overflows. Bits WIDTH-1..1 are 0.
- R7: With op_i = 3 and b_invert_i = 0, result bit 0 is the overflow-corrected sign of a_i + b_i, that is 1 exactly when the signed sum is negative. The upper bits are 0.
- R8: zero_o is 1 exactly when every result bit is 0. With op_i = 2 and b_invert_i = 1 it therefore flags a_i == b_i.
- R9: b_invert_i also inverts the second operand for op_i = 0 and op_i = 1, giving a_i & ~b_i and a_i | ~b_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| b_invert_i | input | 1 | Invert second operand and force carry into bit 0 |
| op_i | input | 2 | 0 AND, 1 OR, 2 adder sum, 3 set-less-than |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | All result bits are 0 |
| carry_o | output | 1 | Carry out of the top slice |
| overflow_o | output | 1 | Signed overflow of the adder |

## Verification
A broken link in the carry chain shows up on the ports as a wrong sum, carry or overflow flag. It appears only for operand pairs whose carry actually travels through that slice, so the vectors include carries that cross the full word and carries that enter the top bit.

A wrong feedback of the corrected sign shows up only in bit 0 of a set-less-than result. It is most visible when the subtraction overflows, which is why both signed extremes are driven.

Because the block has no state, every fault is visible at the ports as soon as the inputs settle.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_SUM  = 2'd2,
    OP_LESS = 2'd3
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    b_invert_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    sum_o,
  output logic    carry_o
);
  logic b_eff;
  logic half;

  assign b_eff   = b_i ^ b_invert_i;
  assign half    = a_i ^ b_eff;
  assign sum_o   = half ^ carry_i;
  assign carry_o = (a_i & b_eff) | (carry_i & half);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_eff;
      OP_OR:   res_o = a_i | b_eff;
      OP_SUM:  res_o = sum_o;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    b_invert_i,
  input  logic    carry_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    sum_o,
  output logic    carry_o,
  output logic    set_o,
  output logic    ovf_o
);
  logic b_eff_chk;

  alu_slice u_slice (
    .a_i        (a_i),
    .b_i        (b_i),
    .b_invert_i (b_invert_i),
    .carry_i    (carry_i),
    .less_i     (1'b0),
    .op_i       (op_i),
    .res_o      (res_o),
    .sum_o      (sum_o),
    .carry_o    (carry_o)
  );

  assign ovf_o     = carry_i ^ carry_o;
  // sign of the true (infinite precision) difference
  assign set_o     = sum_o ^ ovf_o;
  assign b_eff_chk = b_i ^ b_invert_i;

  always_comb begin
    if (ovf_o) begin
      AST_OVF_SIGNS: assert ((a_i == b_eff_chk) && (sum_o != a_i)); // R5
    end
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o
);
  assign zero_o = ~|res_i;
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_invert_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             overflow_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op_w;
  logic [WIDTH-1:0] res_w;
  logic [WIDTH-1:0] sum_w;
  logic             set_w;
  logic             ovf_w;

  assign op_w = alu_op_e'(op_i);

  for (genvar i = 0; i < WIDTH; i++) begin : gen_bit
    logic cin_w;
    logic cout_w;
    if (i == 0) begin : g_cin0
      assign cin_w = b_invert_i;
    end else begin : g_cinn
      assign cin_w = gen_bit[i-1].cout_w;
    end
    if (i == MSB) begin : g_msb
      alu_msb_slice u_msb (
        .a_i        (a_i[i]),
        .b_i        (b_i[i]),
        .b_invert_i (b_invert_i),
        .carry_i    (cin_w),
        .op_i       (op_w),
        .res_o      (res_w[i]),
        .sum_o      (sum_w[i]),
        .carry_o    (cout_w),
        .set_o      (set_w),
        .ovf_o      (ovf_w)
      );
    end else begin : g_mid
      logic less_w;
      // only bit 0 receives the fed-back sign
      assign less_w = (i == 0) ? set_w : 1'b0;
      alu_slice u_slice (
        .a_i        (a_i[i]),
        .b_i        (b_i[i]),
        .b_invert_i (b_invert_i),
        .carry_i    (cin_w),
        .less_i     (less_w),
        .op_i       (op_w),
        .res_o      (res_w[i]),
        .sum_o      (sum_w[i]),
        .carry_o    (cout_w)
      );
    end
  end

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .res_i  (res_w),
    .zero_o (zero_o)
  );

  assign result_o   = res_w;
  assign carry_o    = gen_bit[MSB].cout_w;
  assign overflow_o = ovf_w;

  logic [WIDTH-1:0] b_eff_chk;
  logic [WIDTH:0]   ref_sum;
  assign b_eff_chk = b_invert_i ? ~b_i : b_i;
  assign ref_sum   = {1'b0, a_i} + {1'b0, b_eff_chk} + {{WIDTH{1'b0}}, b_invert_i};

  always_comb begin
    AST_SUM_CHAIN: assert ({carry_o, sum_w} == ref_sum); // R3
    if (op_w == OP_AND) begin
      AST_AND_SEL: assert (result_o == (a_i & b_eff_chk)); // R1
    end
    if (op_w == OP_LESS) begin
      AST_LESS_UPPER: assert (result_o[MSB:1] == '0); // R6
    end
    if (op_w == OP_LESS && b_invert_i) begin
      AST_LESS_SIGNED: assert (result_o[0] == ($signed(a_i) < $signed(b_i))); // R6
    end
    if (op_w == OP_SUM && b_invert_i) begin
      AST_EQ_ZERO: assert (zero_o == (a_i == b_i)); // R8
    end
  end
endmodule

// File: tb/tb_alu_ripple.sv
module tb_alu_ripple;
  localparam int W = 32;
  localparam int N = 13;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic         binv, zero, cy, ovf;
  logic [1:0]   op;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  alu_ripple #(.WIDTH(W)) dut (
    .a_i(a), .b_i(b), .b_invert_i(binv), .op_i(op),
    .result_o(res), .zero_o(zero), .carry_o(cy), .overflow_o(ovf)
  );

  // a, b, binv, op, requirement number
  localparam logic [W-1:0] TA [N] = '{32'hFFFF0000, 32'h12345678, 32'h00000005,
    32'h7FFFFFFF, 32'h00000003, 32'h00000009, 32'hFFFFFFFE, 32'h00000003,
    32'h80000000, 32'hAAAAAAAA, 32'h00000000, 32'h00000004, 32'h40000000};
  localparam logic [W-1:0] TB [N] = '{32'h0F0F0F0F, 32'hFFFF0000, 32'h00000007,
    32'h00000001, 32'h00000005, 32'h00000002, 32'h00000003, 32'hFFFFFFFE,
    32'h80000000, 32'h0000FFFF, 32'hF0F0F0F0, 32'h00000004, 32'h40000000};
  localparam logic       TI [N] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 1, 1, 1, 0};
  localparam logic [1:0] TO [N] = '{0, 1, 2, 2, 2, 2, 3, 3, 2, 0, 1, 3, 3};
  // R1 R2 R3 R5 R4 R4 R6 R6 R5 R9 R9 R8 R7
  localparam int         TR [N] = '{1, 2, 3, 5, 4, 4, 6, 6, 5, 9, 9, 8, 7};

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic iv, input logic [1:0] ov);
    @(negedge clk);
    a = av; b = bv; binv = iv; op = ov;
    #5;
  endtask

  // expected behaviour from the requirements
  task automatic expect_all(input string tag);
    logic [W-1:0] bb, er;
    logic [W:0]   s;
    logic         ev, ls;
    bb = binv ? ~b : b;
    s  = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, binv};
    ev = (a[W-1] == bb[W-1]) && (s[W-1] != a[W-1]);
    ls = binv ? ($signed(a) < $signed(b)) : ($signed({a[W-1], a}) + $signed({bb[W-1], bb}) < 0);
    case (op)
      2'd0: er = a & bb;
      2'd1: er = a | bb;
      2'd2: er = s[W-1:0];
      default: er = {{(W-1){1'b0}}, ls};
    endcase
    chk({tag, " result"}, res, er);
    chk({tag, " zero"}, {31'd0, zero}, {31'd0, er == '0});
    chk({tag, " carry"}, {31'd0, cy}, {31'd0, s[W]});
    chk({tag, " overflow"}, {31'd0, ovf}, {31'd0, ev});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; binv = 1'b0; op = 2'd0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #5;
    chk("R8 reset result", res, '0);
    chk("R8 reset zero", {31'd0, zero}, 32'd1);

    for (int k = 0; k < N; k++) begin
      apply(TA[k], TB[k], TI[k], TO[k]);
      expect_all($sformatf("R%0d vec%0d", TR[k], k));
    end

    // R5 R6: max minus -1 overflows, slt must still be 0
    apply(32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, 2'd3);
    chk("R6 slt max<-1", res, 32'h0);
    chk("R5 ovf max-(-1)", {31'd0, ovf}, 32'd1);
    // R6: min < 1 with overflowing subtraction
    apply(32'h80000000, 32'h00000001, 1'b1, 2'd3);
    chk("R6 slt min<1", res, 32'h1);
    chk("R6 zero clear", {31'd0, zero}, 32'd0);
    // R4 R8: equal compare
    apply(32'h00000005, 32'h00000005, 1'b1, 2'd2);
    chk("R8 beq zero", {31'd0, zero}, 32'd1);
    chk("R4 no borrow carry", {31'd0, cy}, 32'd1);
    // R4: borrow clears carry
    apply(32'h00000003, 32'h00000005, 1'b1, 2'd2);
    chk("R4 borrow result", res, 32'hFFFFFFFE);
    chk("R4 borrow carry", {31'd0, cy}, 32'd0);
    // R3: carry through the full chain
    apply(32'hFFFFFFFF, 32'h00000001, 1'b0, 2'd2);
    chk("R3 wrap result", res, 32'h0);
    chk("R3 wrap carry", {31'd0, cy}, 32'd1);
    chk("R5 wrap no ovf", {31'd0, ovf}, 32'd0);
    // R9: inverted operand in logic ops
    apply(32'hF0F0F0F0, 32'hFF00FF00, 1'b1, 2'd0);
    chk("R9 and not", res, 32'h00F000F0);
    // R7: sign of sum with overflow correction
    apply(32'h80000000, 32'h80000000, 1'b0, 2'd3);
    chk("R7 neg sum sign", res, 32'h1);
    // R1 R2 plain
    apply(32'hC3C3C3C3, 32'h0FF00FF0, 1'b0, 2'd1);
    chk("R2 or", res, 32'hCFF3CFF3);
    apply(32'hC3C3C3C3, 32'h0FF00FF0, 1'b0, 2'd0);
    chk("R1 and", res, 32'h03C003C0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule